// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a clocked single-port memory with a shared bidirectional data bus. Every input, including the write data taken from the bus, is captured in a register on the rising clock edge. The access then runs in the following cycle. Read data passes through one more register before it is driven onto the bus. Either of two address strobes opens an access at an external address. After that, an advance input walks a 2-bit burst counter over the two low address bits, in either linear or interleaved order.

Writes are decoded from a global write control and a byte-write control with per-lane enables. Each lane is half of the word, so a parity bit travels with its byte. Three chip enables qualify every strobe. A sleep input freezes all accesses and needs one clock of recovery after it is released. The default size is 1K words of 18 bits.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset no burst is open, so advance and continuation cycles write nothing until a strobe starts an access.
- R2: A read whose inputs are registered at edge k drives its word on the bus after edge k+2. Back-to-back reads stream one word per clock. The bus is released when no read is pending.
- R3: A write completes in the cycle after its inputs are registered, with no external strobe. A read registered one edge after the write returns the new data.
- R4: With global write low (0), both lanes are written whatever the byte-write and lane enables are.
- R5: With global write high and byte-write low, lane enable 0 (active low) writes bits [8:0] and lane enable 1 writes bits [17:9]. With both write controls high, the access is a read and the memory is unchanged.
- R6: A strobe is accepted only when ce1_n=0, ce2=1 and ce3_n=0. A strobe with any enable inactive performs no access and ends the open burst.
- R7: An access opened by the processor strobe is always a read. When both strobes are low together, the processor strobe wins, so nothing is written.
- R8: With order_sel=0, each registered advance adds 1 (mod 4) to the burst counter. The two low address bits are base+count mod 4, and the upper bits stay at the base.
- R9: With order_sel=1, the two low address bits are base XOR count.
- R10: In an open burst, a cycle with no strobe and no advance repeats the access at the current burst address without stepping.
- R11: While sleep is registered high, and for one cycle after it is registered low, strobes and advance are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External word address |
| dq | inout | DW | Shared data bus |
| proc_strb_n | input | 1 | Processor address strobe, active low, read-only start |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| glob_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Per-lane write qualifier, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Suspend all accesses |

## Verification
A read is due on the bus at the falling edge that follows the second rising edge after its strobe is registered. The bench therefore drives at falling edges and samples exactly three falling edges after the strobe. In the streamed table loop, the word checked at each falling edge is the one strobed three vectors earlier. Writes and ignored strobes have no immediate output, so their effect is checked by a later read. Every write is preceded by a deselect and two drain cycles, which ensures the bus has been released before the bench drives it.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW    = 10,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  inout  wire  [DW-1:0]    dq,
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             glob_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             order_sel,
  input  logic             sleep
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0]    s_addr;
  logic [DW-1:0]    s_din;
  logic             s_ps, s_cs, s_adv, s_sel, s_gw, s_bw, s_ord, s_slp, wake_q;
  logic [LANES-1:0] s_en;

  logic          act_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [DW-1:0] rd_q, out_q;
  logic          rd_v, out_v;

  assign dq = out_v ? out_q : {DW{1'bz}};

  logic blk, strobe, start, desel, step, hold, acc, is_wr;
  logic [1:0]       nxt_cnt, blo, lo;
  logic [AW-3:0]    bhi;
  logic [AW-1:0]    eff;
  logic [LANES-1:0] lane_we;

  assign blk     = s_slp | wake_q;
  assign strobe  = s_ps | s_cs;
  assign start   = !blk && strobe && s_sel;
  assign desel   = !blk && strobe && !s_sel;
  assign step    = !blk && !strobe && act_q && s_adv;
  assign hold    = !blk && !strobe && act_q && !s_adv;
  assign acc     = start | step | hold;
  assign nxt_cnt = start ? 2'd0 : (step ? cnt_q + 2'd1 : cnt_q);
  assign blo     = start ? s_addr[1:0] : base_q[1:0];
  assign bhi     = start ? s_addr[AW-1:2] : base_q[AW-1:2];
  assign lo      = s_ord ? (blo ^ nxt_cnt) : (blo + nxt_cnt);
  assign eff     = {bhi, lo};
  assign lane_we = (start && s_ps) ? '0 :
                   s_gw            ? '1 :
                   s_bw            ? s_en : '0;
  assign is_wr   = |lane_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr <= '0; s_din <= '0; s_en <= '0;
      s_ps <= 1'b0; s_cs <= 1'b0; s_adv <= 1'b0; s_sel <= 1'b0;
      s_gw <= 1'b0; s_bw <= 1'b0; s_ord <= 1'b0; s_slp <= 1'b0; wake_q <= 1'b0;
      act_q <= 1'b0; base_q <= '0; cnt_q <= '0;
      rd_q <= '0; rd_v <= 1'b0; out_q <= '0; out_v <= 1'b0;
    end else begin
      s_addr <= addr;
      s_din  <= dq;
      s_ps   <= !proc_strb_n;
      s_cs   <= !ctrl_strb_n;
      s_adv  <= !adv_n;
      s_sel  <= !ce1_n && ce2 && !ce3_n;
      s_gw   <= !glob_wr_n;
      s_bw   <= !byte_wr_n;
      s_en   <= ~lane_en_n;
      s_ord  <= order_sel;
      s_slp  <= sleep;
      wake_q <= s_slp;
      if (start) begin
        act_q  <= 1'b1;
        base_q <= s_addr;
      end else if (desel) begin
        act_q <= 1'b0;
      end
      if (acc) cnt_q <= nxt_cnt;
      rd_v <= acc && !is_wr;
      if (acc && !is_wr) rd_q <= mem[eff];
      out_v <= rd_v;
      out_q <= rd_q;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (acc && lane_we[l]) mem[eff][l*LW +: LW] <= s_din[l*LW +: LW];
  end

  assert_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v |=> (out_v && out_q == $past(rd_q)));
  assert_write_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_wr) |=> !rd_v);
  assert_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !s_sel && !blk) |=> !act_q);
  assert_proc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && s_ps) |=> rd_v);
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) + 2'd1));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_q));
  assert_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_slp || wake_q) |=> !rd_v);
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [17:0] tb_d = '0;
  logic tb_oe = 1'b0;
  wire  [17:0] dq;
  logic proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic glob_wr_n = 1'b1, byte_wr_n = 1'b1;
  logic [1:0] lane_en_n = 2'b11;
  logic order_sel = 1'b0, sleep = 1'b0;

  assign dq = tb_oe ? tb_d : 18'bz;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq(dq),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
    .order_sel(order_sel), .sleep(sleep));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [17:0] shadow [1024];

  localparam logic [27:0] VEC [8] = '{
    {10'h020, 18'h0A0A0}, {10'h021, 18'h1B1B1}, {10'h022, 18'h2C2C2},
    {10'h023, 18'h3D3D3}, {10'h000, 18'h00F0F}, {10'h155, 18'h15555},
    {10'h2AA, 18'h2AAAA}, {10'h3FF, 18'h3FFFE}};

  task automatic tk(); @(negedge clk); endtask

  task automatic idle();
    proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    glob_wr_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 2'b11;
    sleep = 1'b0; tb_oe = 1'b0;
  endtask

  task automatic desel_drive();
    idle(); ctrl_strb_n = 1'b0; ce1_n = 1'b1;
  endtask

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(input logic [9:0] a, input logic [17:0] d, input logic ps, input logic cs,
                    input logic [2:0] ce, input logic gw, input logic bw, input logic [1:0] en);
    idle();
    addr = a; tb_d = d; tb_oe = 1'b1;
    proc_strb_n = ps; ctrl_strb_n = cs;
    ce1_n = ce[2]; ce2 = ce[1]; ce3_n = ce[0];
    glob_wr_n = gw; byte_wr_n = bw; lane_en_n = en;
    tk(); desel_drive(); tk(); idle(); tk(); tk();
  endtask

  task automatic wr(input logic [9:0] a, input logic [17:0] d);
    op(a, d, 1'b1, 1'b0, 3'b010, 1'b0, 1'b1, 2'b11);
    shadow[a] = d;
  endtask

  task automatic rd_check(input logic [9:0] a, input string req);
    idle(); addr = a; proc_strb_n = 1'b0;
    tk(); desel_drive(); tk(); idle(); tk();
    check(req, dq, shadow[a]);
    tk();
  endtask

  task automatic burst(input logic [9:0] base, input logic ord, input logic [2:0] advs,
                       input string req);
    logic [1:0] n = 2'd0;
    logic [1:0] exp_n [4];
    exp_n[0] = 2'd0;
    for (int i = 1; i < 4; i++) begin
      n = n + {1'b0, advs[i-1]};
      exp_n[i] = n;
    end
    idle(); order_sel = ord; addr = base; proc_strb_n = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      tk();
      if (c >= 3) begin
        logic [9:0] ea;
        ea[9:2] = base[9:2];
        ea[1:0] = ord ? (base[1:0] ^ exp_n[c-3]) : (base[1:0] + exp_n[c-3]);
        check(req, dq, shadow[ea]);
      end
      if (c <= 3) begin idle(); adv_n = !advs[c-1]; end
      else if (c == 4) desel_drive();
      else idle();
    end
    tk(); order_sel = 1'b0;
  endtask

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tk();
    rst_n = 1'b1;
    tk();

    // R1: burst closed after reset; advance writes and continuation reads are inert
    wr(10'h000, 18'h12345); wr(10'h001, 18'h23456);
    rst_n = 1'b0; tk(); tk(); rst_n = 1'b1; tk();
    idle(); adv_n = 1'b0; glob_wr_n = 1'b0; tb_d = 18'h3FFFF; tb_oe = 1'b1; tk();
    idle(); glob_wr_n = 1'b0; tb_d = 18'h3FFFF; tb_oe = 1'b1; tk();
    idle(); tk(); tk();
    rd_check(10'h000, "R1 addr0 untouched");
    rd_check(10'h001, "R1 addr1 untouched");

    // R4: table writes via global write, lane enables left inactive
    for (int i = 0; i < 8; i++) wr(VEC[i][27:18], VEC[i][17:0]);

    // R2: streamed reads, word i due three falling edges after its strobe
    for (int j = 0; j <= 10; j++) begin
      if (j >= 3) check("R2/R4 streamed read", dq, VEC[j-3][17:0]);
      if (j < 8) begin idle(); addr = VEC[j][27:18]; proc_strb_n = 1'b0; end
      else if (j == 8) desel_drive();
      else idle();
      tk();
    end
    tk();

    // R3: read registered one edge after a write sees the new data
    idle(); addr = 10'h040; tb_d = 18'h2468A; tb_oe = 1'b1; ctrl_strb_n = 1'b0; glob_wr_n = 1'b0;
    tk(); idle(); addr = 10'h040; proc_strb_n = 1'b0;
    tk(); desel_drive(); tk(); idle(); tk();
    check("R3 write then read", dq, 18'h2468A);
    shadow[10'h040] = 18'h2468A;
    tk();

    // R5: lane writes carry their parity bit
    wr(10'h050, 18'h00000);
    op(10'h050, 18'h3FFFF, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0, 2'b10);
    shadow[10'h050] = 18'h001FF;
    rd_check(10'h050, "R5 low lane");
    wr(10'h051, 18'h00000);
    op(10'h051, 18'h3FFFF, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0, 2'b01);
    shadow[10'h051] = 18'h3FE00;
    rd_check(10'h051, "R5 high lane");
    op(10'h051, 18'h15A5A, 1'b1, 1'b0, 3'b010, 1'b1, 1'b1, 2'b00);
    rd_check(10'h051, "R5 no write controls");
    // R4: global write overrides a byte-write with lanes disabled
    op(10'h051, 18'h0C3C3, 1'b1, 1'b0, 3'b010, 1'b0, 1'b0, 2'b11);
    shadow[10'h051] = 18'h0C3C3;
    rd_check(10'h051, "R4 global override");

    // R6: each inactive chip enable blocks the write
    op(10'h020, 18'h11111, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 2'b11);
    rd_check(10'h020, "R6 ce2 low");
    op(10'h021, 18'h11111, 1'b1, 1'b0, 3'b011, 1'b0, 1'b1, 2'b11);
    rd_check(10'h021, "R6 ce3_n high");
    op(10'h022, 18'h11111, 1'b1, 1'b0, 3'b110, 1'b0, 1'b1, 2'b11);
    rd_check(10'h022, "R6 ce1_n high");

    // R7: processor strobe forces a read, also when both strobes are low
    op(10'h023, 18'h22222, 1'b0, 1'b0, 3'b010, 1'b0, 1'b1, 2'b11);
    rd_check(10'h023, "R7 both strobes");
    op(10'h023, 18'h22222, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0, 2'b00);
    rd_check(10'h023, "R7 processor strobe");

    // R8 / R9 / R10: burst orders and hold
    burst(10'h021, 1'b0, 3'b111, "R8 linear burst");
    burst(10'h021, 1'b1, 3'b111, "R9 interleaved burst");
    burst(10'h022, 1'b1, 3'b111, "R9 interleaved base 2");
    burst(10'h021, 1'b0, 3'b110, "R10 hold then advance");

    // R11: sleep and one recovery cycle drop strobes
    wr(10'h060, 18'h06060); wr(10'h061, 18'h06161); wr(10'h062, 18'h06262);
    idle(); sleep = 1'b1; tk();
    idle(); sleep = 1'b1; addr = 10'h060; tb_d = 18'h3AAAA; tb_oe = 1'b1;
    ctrl_strb_n = 1'b0; glob_wr_n = 1'b0; tk();
    idle(); addr = 10'h061; tb_d = 18'h3BBBB; tb_oe = 1'b1;
    ctrl_strb_n = 1'b0; glob_wr_n = 1'b0; tk();
    idle(); addr = 10'h062; tb_d = 18'h3CCCC; tb_oe = 1'b1;
    ctrl_strb_n = 1'b0; glob_wr_n = 1'b0; tk();
    desel_drive(); tk(); idle(); tk(); tk();
    shadow[10'h062] = 18'h3CCCC;
    rd_check(10'h060, "R11 during sleep");
    rd_check(10'h061, "R11 recovery cycle");
    rd_check(10'h062, "R11 after recovery");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule